// File: doc/BRIEF.md
# Prioritized Interrupt Vector Encoder

This block sits between the event sources of a serial bus controller and a host processor. Seven single-cycle event pulses come in: arbitration lost, no-acknowledge, register-access ready, receive data ready, transmit data ready, stop detected and addressed-as-slave. Each pulse sets a sticky pending flag. A mask register selects which flags may reach the host. A single level interrupt line is high while any enabled flag is pending.

The host services the line by reading a vector register. The read returns the numeric code of the most urgent enabled pending event and clears that one flag. Repeated vector reads therefore drain every source in priority order, and the host stops when a read returns zero. The host can also clear flags by writing ones to the status register. The data path clears the two data-ready flags when it takes a received byte or accepts a byte to send. Two live bus conditions, bus busy and receive shift full, are shown in the status word for inspection only.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset every pending flag and every mask bit is 0, `irq_o` is low, and the status, mask and vector reads return 0 while the bus-busy and shift-full inputs are low.
- R2: A pulse on `ev_i[k]` sets pending flag k, and the flag stays set until it is cleared. Flag k reads back at status bit k: 0 arbitration lost, 1 no-acknowledge, 2 access ready, 3 receive ready, 4 transmit ready, 5 stop detected, 6 addressed-as-slave.
- R3: A write to the status register (offset 0x08) clears each flag whose data bit is 1. Flags whose data bit is 0 are unchanged.
- R4: The mask register (offset 0x04) holds the 7 bits written to it, uses the same bit positions as the flags, reads back upper bits as 0, and changes only when it is written.
- R5: A vector read (offset 0x28) returns k+1 for the lowest index k that is both pending and enabled. The codes are 1 arbitration lost, 2 no-acknowledge, 3 access ready, 4 receive ready, 5 transmit ready, 6 stop detected, 7 addressed-as-slave. The read returns 0 when no enabled flag is pending.
- R6: A vector read that returns a nonzero code clears only the flag it reports.
- R7: `irq_o` is high exactly when at least one flag is both pending and enabled.
- R8: A pulse on `rx_pop_i` clears the receive-ready flag, and a pulse on `tx_push_i` clears the transmit-ready flag.
- R9: Status bit 11 mirrors `rx_shift_full_i` and status bit 12 mirrors `bus_busy_i`. Neither has a mask bit, and neither affects the vector or `irq_o`.
- R10: A masked event still sets its status flag but produces no vector code and no interrupt.
- R11: If an event pulse and a clear of the same flag fall in the same cycle, the flag ends up set.
- R12: Reads of unmapped offsets return 0, and writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_i | input | 7 | Event pulses, one bit per source |
| rx_pop_i | input | 1 | Received byte taken; clears receive-ready |
| tx_push_i | input | 1 | Byte accepted for sending; clears transmit-ready |
| bus_busy_i | input | 1 | Live bus-busy condition |
| rx_shift_full_i | input | 1 | Live receive-shift-full condition |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, combinational from address |
| irq_o | output | 1 | Interrupt request to the host |

## Verification
The hardest case to reach is a single drain sequence that walks through all seven codes. It needs every source pending at once with the mask fully open, and then back-to-back vector reads in which each read removes exactly one flag. The stimulus fires all seven event bits in one cycle and then reads the vector eight times, expecting 1 through 7 and then 0. A second hard case is a clear and an event that land on the same flag in the same edge. The bench forces this by driving a status write and the matching event pulse in the same cycle.

// File: rtl/irq_vector_unit.sv
module irq_vector_unit #(
  parameter int NEV = 7,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] MASK_OFS = 8'h04,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h08,
  parameter logic [ADDR_W-1:0] VEC_OFS  = 8'h28,
  parameter int RX_IDX = 3,
  parameter int TX_IDX = 4,
  parameter int RSF_BIT = 11,
  parameter int BUSY_BIT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NEV-1:0]    ev_i,
  input  logic              rx_pop_i,
  input  logic              tx_push_i,
  input  logic              bus_busy_i,
  input  logic              rx_shift_full_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam int CODE_W = $clog2(NEV + 1);

  logic [NEV-1:0]    pend, mask, act, win, w1c, vclr, dclr;
  logic [CODE_W-1:0] vec_code;
  logic              hit_mask, hit_stat, hit_vec;

  assign hit_mask = reg_addr_i == MASK_OFS;
  assign hit_stat = reg_addr_i == STAT_OFS;
  assign hit_vec  = reg_addr_i == VEC_OFS;

  assign act = pend & mask;
  assign win = act & (~act + 1'b1);

  always_comb begin
    vec_code = '0;
    for (int i = NEV - 1; i >= 0; i--)
      if (act[i]) vec_code = CODE_W'(i + 1);
  end

  assign w1c  = (reg_wr_i && hit_stat) ? reg_wdata_i[NEV-1:0] : '0;
  assign vclr = (reg_rd_i && hit_vec) ? win : '0;

  always_comb begin
    dclr = '0;
    dclr[RX_IDX] = rx_pop_i;
    dclr[TX_IDX] = tx_push_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      mask <= '0;
    end else begin
      pend <= (pend & ~(w1c | vclr | dclr)) | ev_i;
      if (reg_wr_i && hit_mask) mask <= reg_wdata_i[NEV-1:0];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (hit_mask) reg_rdata_o[NEV-1:0] = mask;
    else if (hit_stat) begin
      reg_rdata_o[NEV-1:0]  = pend;
      reg_rdata_o[RSF_BIT]  = rx_shift_full_i;
      reg_rdata_o[BUSY_BIT] = bus_busy_i;
    end else if (hit_vec) reg_rdata_o[CODE_W-1:0] = vec_code;
  end

  assign irq_o = |act;

  wire unused_ok = &{1'b0, reg_wdata_i[DATA_W-1:NEV]};
endmodule

// File: rtl/irq_vector_chk.sv
module irq_vector_chk #(
  parameter int NEV = 7,
  parameter int ADDR_W = 8,
  parameter int CODE_W = 3,
  parameter logic [ADDR_W-1:0] MASK_OFS = 8'h04,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h08,
  parameter logic [ADDR_W-1:0] VEC_OFS  = 8'h28
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NEV-1:0]    ev_i,
  input logic              reg_wr_i,
  input logic              reg_rd_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [NEV-1:0]    wdata_lo,
  input logic [NEV-1:0]    pend,
  input logic [NEV-1:0]    mask,
  input logic [NEV-1:0]    win,
  input logic [CODE_W-1:0] vec_code,
  input logic              irq_o
);
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i != '0) |=> ((pend & $past(ev_i)) == $past(ev_i)));

  p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == STAT_OFS) |=> ((pend & $past(wdata_lo & ~ev_i)) == '0));

  p_mask_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_i && reg_addr_i == MASK_OFS) |=> $stable(mask));

  p_vec_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_i && reg_addr_i == VEC_OFS && vec_code != '0 && (ev_i & win) == '0)
      |=> ((pend & $past(win)) == '0));

  p_irq_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (vec_code != '0));

  p_masked_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq_o);
endmodule

bind irq_vector_unit irq_vector_chk #(
  .NEV(NEV), .ADDR_W(ADDR_W), .CODE_W(CODE_W),
  .MASK_OFS(MASK_OFS), .STAT_OFS(STAT_OFS), .VEC_OFS(VEC_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i),
  .reg_addr_i(reg_addr_i), .wdata_lo(reg_wdata_i[NEV-1:0]), .pend(pend), .mask(mask),
  .win(win), .vec_code(vec_code), .irq_o(irq_o)
);

// File: tb/tb_irq_vector_unit.sv
`timescale 1ns/1ps
module tb_irq_vector_unit;
  logic clk = 0, rst_n = 0;
  logic [6:0] ev_i = '0;
  logic rx_pop_i = 0, tx_push_i = 0, bus_busy_i = 0, rx_shift_full_i = 0;
  logic reg_wr_i = 0, reg_rd_i = 0;
  logic [7:0] reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0, reg_rdata_o;
  logic irq_o;
  int checks = 0, fails = 0;
  bit done = 0;

  localparam logic [7:0] A_MASK = 8'h04, A_STAT = 8'h08, A_VEC = 8'h28;

  // {mask, events, expected code, expected irq}
  localparam logic [17:0] TBL [8] = '{
    {7'h7F, 7'h01, 3'd1, 1'b1},
    {7'h7F, 7'h7E, 3'd2, 1'b1},
    {7'h7F, 7'h60, 3'd6, 1'b1},
    {7'h7F, 7'h40, 3'd7, 1'b1},
    {7'h10, 7'h1F, 3'd5, 1'b1},
    {7'h00, 7'h7F, 3'd0, 1'b0},
    {7'h78, 7'h0C, 3'd4, 1'b1},
    {7'h7F, 7'h14, 3'd3, 1'b1}
  };

  irq_vector_unit dut (.*);

  always #10 clk = ~clk;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk); reg_wr_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk); reg_wr_i = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [15:0] d);
    @(negedge clk); reg_rd_i = 1; reg_addr_i = a;
    #1 d = reg_rdata_o;
    @(negedge clk); reg_rd_i = 0;
  endtask

  task automatic pulse(logic [6:0] e);
    @(negedge clk); ev_i = e;
    @(negedge clk); ev_i = '0;
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", irq_o, 0);
    rd(A_STAT, d); check("R1 status", d, 0);
    rd(A_MASK, d); check("R1 mask", d, 0);
    rd(A_VEC, d);  check("R1 vector", d, 0);

    // R5 R7 R10 table
    for (int i = 0; i < 8; i++) begin
      wr(A_STAT, 16'h007F);
      wr(A_MASK, {9'd0, TBL[i][17:11]});
      pulse(TBL[i][10:4]);
      check("R7 irq table", irq_o, int'(TBL[i][0]));
      rd(A_VEC, d);
      check("R5 code table", d, int'(TBL[i][3:1]));
    end

    // R10 masked still recorded
    wr(A_STAT, 16'h007F); wr(A_MASK, 16'h0000);
    pulse(7'h02);
    rd(A_STAT, d); check("R10 status recorded", d, 16'h0002);
    check("R10 irq low", irq_o, 0);

    // R2 all positions and stickiness
    wr(A_STAT, 16'h007F);
    pulse(7'h7F);
    repeat (3) @(negedge clk);
    rd(A_STAT, d); check("R2 sticky all", d, 16'h007F);

    // R4 mask width and readback
    wr(A_MASK, 16'hFFFF);
    rd(A_MASK, d); check("R4 mask readback", d, 16'h007F);

    // R6 drain all seven in order
    for (int k = 1; k <= 7; k++) begin
      rd(A_VEC, d); check("R6 drain code", d, k);
    end
    rd(A_VEC, d); check("R6 drain empty", d, 0);
    check("R7 irq after drain", irq_o, 0);

    // R6 only reported flag cleared
    pulse(7'h05);
    rd(A_VEC, d); check("R6 code", d, 1);
    rd(A_STAT, d); check("R6 others kept", d, 16'h0004);

    // R3 write one clears, zero ignored
    wr(A_STAT, 16'h007F);
    pulse(7'h25);
    wr(A_STAT, 16'h0004);
    rd(A_STAT, d); check("R3 w1c", d, 16'h0021);
    wr(A_STAT, 16'h0000);
    rd(A_STAT, d); check("R3 w0 no effect", d, 16'h0021);

    // R8 data path clears
    wr(A_STAT, 16'h007F);
    pulse(7'h18);
    @(negedge clk); rx_pop_i = 1; @(negedge clk); rx_pop_i = 0;
    rd(A_STAT, d); check("R8 rx pop", d, 16'h0010);
    @(negedge clk); tx_push_i = 1; @(negedge clk); tx_push_i = 0;
    rd(A_STAT, d); check("R8 tx push", d, 16'h0000);

    // R9 live status bits
    bus_busy_i = 1; rx_shift_full_i = 1;
    rd(A_STAT, d); check("R9 live bits", d, 16'h1800);
    check("R9 irq", irq_o, 0);
    rd(A_VEC, d); check("R9 vector", d, 0);
    bus_busy_i = 0; rx_shift_full_i = 0;

    // R11 set beats clear in same cycle
    pulse(7'h01);
    @(negedge clk); reg_wr_i = 1; reg_addr_i = A_STAT; reg_wdata_i = 16'h0001; ev_i = 7'h01;
    @(negedge clk); reg_wr_i = 0; ev_i = '0;
    rd(A_STAT, d); check("R11 set wins", d, 16'h0001);

    // R12 unmapped
    wr(8'h0C, 16'hFFFF);
    rd(A_MASK, d); check("R12 mask untouched", d, 16'h007F);
    rd(A_STAT, d); check("R12 status untouched", d, 16'h0001);
    rd(8'h0C, d); check("R12 unmapped read", d, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule